// File: doc/BRIEF.md
# Next-PC Sequencer

This block owns the program counter of a processor that completes one instruction per clock. Every instruction is one aligned word. On each rising clock edge it loads the address of the next instruction. That address is one of three values: the word that follows in memory, a target relative to that next word for a taken compare-equal branch, or an absolute target built from a field of the current instruction, which keeps the region bits of the current flow.

The surrounding core decodes the instruction and drives the block's inputs: the branch flag, the jump flag, the zero result of the register subtraction, the 16-bit immediate and the 26-bit jump field. The block drives the current PC to the instruction memory address. It also exposes the incremented PC to other logic, such as a link-register path. Inside the block, a small control unit turns the flags into two mux selects. A datapath unit holds the register, the adders and the two-stage selection chain.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the PC loads 0x00000000. Reset takes precedence over every other input.
- R2: `pcPlus4` always equals `pcOut + 4`, taken modulo 2^32.
- R3: If neither `isBranchEq` nor `isJump` is high, the next PC is `pcPlus4`.
- R4: If `isBranchEq` and `aluZero` are both high and `isJump` is low, the next PC is `pcPlus4` plus the sign-extended 16-bit `immField` multiplied by four. Bit 15 of the immediate is the sign.
- R5: If `isBranchEq` is high and `aluZero` is low and `isJump` is low, the next PC is `pcPlus4`.
- R6: If `isJump` is high, the next PC is built from three parts. Bits 31:28 are `pcPlus4[31:28]`, bits 27:2 are `jumpField[25:0]`, and bits 1:0 are zero.
- R7: If `isJump` and `isBranchEq` are both high, the jump target of R6 is loaded whatever the value of `aluZero`.
- R8: `aluZero` has no effect on the next PC unless `isBranchEq` is high.
- R9: Bits 1:0 of `pcOut` are zero in every cycle.
- R10: Sequential advance from 0xFFFFFFFC wraps to 0x00000000, and branch targets wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| immField | input | 16 | Branch offset in words, two's complement |
| jumpField | input | 26 | Word index of the jump target inside the current region |
| isBranchEq | input | 1 | Current instruction is a compare-equal branch |
| isJump | input | 1 | Current instruction is an absolute jump |
| aluZero | input | 1 | Register subtraction result is zero |
| pcOut | output | 32 | Current PC, drives the instruction memory address |
| pcPlus4 | output | 32 | Current PC plus four |

## Verification
The PC is the only state in this block. Any wrong selection or adder result therefore shows on `pcOut` at the very next rising edge, and it shows on `pcPlus4` in the same cycle. A wrong select or a wrong offset sign stays visible, because every later address is offset from the corrupted value. The bench keeps its own model of the PC. It compares both outputs after every edge, so a fault is reported in the cycle where it first appears. Directed cases cover negative offsets, the flag conflict, region bits that come from the incremented PC, and wrap at the top of the address space. Several hundred pseudo-random cycles follow them.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  // Mux selects passed from the control unit to the datapath
  typedef struct packed {
    logic selBranch;  // first mux: branch target instead of incremented PC
    logic selJump;    // second mux: region jump address instead of first mux
  } pcSelT;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic  isBranchEq,
  input  logic  isJump,
  input  logic  aluZero,
  output pcSelT sel
);

  // Branch taken only on equality; the jump select sits later in the chain
  // and therefore overrides the branch path without extra gating here.
  always_comb begin
    sel.selBranch = isBranchEq & aluZero;
    sel.selJump   = isJump;
  end

endmodule

// File: rtl/pc_seq_datapath.sv
module pc_seq_datapath
  import pc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned JFIELD_W   = 26,
  parameter int unsigned STEP_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  pcSelT               sel,
  input  logic [IMM_W-1:0]    immField,
  input  logic [JFIELD_W-1:0] jumpField,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   pcPlus4
);

  localparam int unsigned SHIFT_W  = $clog2(STEP_BYTES);
  localparam int unsigned EXT_W    = ADDR_W - IMM_W - SHIFT_W;
  localparam int unsigned REGION_W = ADDR_W - JFIELD_W - SHIFT_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] incPc;
  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] firstMux;
  logic [ADDR_W-1:0] nextPc;

  // Dedicated incrementer: constant step on one input
  always_comb incPc = pcReg + ADDR_W'(STEP_BYTES);

  // Sign extension and word scaling in one wiring step
  always_comb offsetExt = {{EXT_W{immField[IMM_W-1]}}, immField, {SHIFT_W{1'b0}}};

  always_comb branchTarget = incPc + offsetExt;

  // Region bits come from the incremented PC, not the current one
  always_comb jumpTarget = {incPc[ADDR_W-1 -: REGION_W], jumpField, {SHIFT_W{1'b0}}};

  // Two-stage select chain
  always_comb firstMux = sel.selBranch ? branchTarget : incPc;
  always_comb nextPc   = sel.selJump   ? jumpTarget   : firstMux;

  always_ff @(posedge clk) begin
    if (rst) pcReg <= RESET_ADDR;
    else     pcReg <= nextPc;
  end

  assign pcOut   = pcReg;
  assign pcPlus4 = incPc;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned JFIELD_W   = 26,
  parameter int unsigned STEP_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IMM_W-1:0]    immField,
  input  logic [JFIELD_W-1:0] jumpField,
  input  logic                isBranchEq,
  input  logic                isJump,
  input  logic                aluZero,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   pcPlus4
);

  pcSelT sel;

  pc_seq_ctrl u_ctrl (
    .isBranchEq (isBranchEq),
    .isJump     (isJump),
    .aluZero    (aluZero),
    .sel        (sel)
  );

  pc_seq_datapath #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .JFIELD_W   (JFIELD_W),
    .STEP_BYTES (STEP_BYTES),
    .RESET_ADDR (RESET_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .immField  (immField),
    .jumpField (jumpField),
    .pcOut     (pcOut),
    .pcPlus4   (pcPlus4)
  );

endmodule

// File: rtl/pc_sequencer_checker.sv
module pc_sequencer_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned JFIELD_W   = 26,
  parameter int unsigned STEP_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input logic                clk,
  input logic                rst,
  input logic [IMM_W-1:0]    immField,
  input logic [JFIELD_W-1:0] jumpField,
  input logic                isBranchEq,
  input logic                isJump,
  input logic                aluZero,
  input logic [ADDR_W-1:0]   pcOut,
  input logic [ADDR_W-1:0]   pcPlus4
);

  localparam int unsigned SHIFT_W  = $clog2(STEP_BYTES);
  localparam int unsigned REGION_W = ADDR_W - JFIELD_W - SHIFT_W;

  logic [ADDR_W-1:0] chkOffset;
  always_comb chkOffset = ADDR_W'($signed(immField)) << SHIFT_W;

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> pcOut == RESET_ADDR);

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    pcPlus4 == pcOut + ADDR_W'(STEP_BYTES));

  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (!isJump && !isBranchEq) |=> pcOut == $past(pcPlus4));

  a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (isBranchEq && aluZero && !isJump) |=> pcOut == $past(pcPlus4) + $past(chkOffset));

  a_r5_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
    (isBranchEq && !aluZero && !isJump) |=> pcOut == $past(pcPlus4));

  // R6 and R7: a jump wins over any branch condition
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    isJump |=> pcOut == {$past(pcPlus4[ADDR_W-1 -: REGION_W]), $past(jumpField), {SHIFT_W{1'b0}}});

  a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
    pcOut[SHIFT_W-1:0] == '0);

endmodule

bind pc_sequencer pc_sequencer_checker #(
  .ADDR_W     (ADDR_W),
  .IMM_W      (IMM_W),
  .JFIELD_W   (JFIELD_W),
  .STEP_BYTES (STEP_BYTES),
  .RESET_ADDR (RESET_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .immField   (immField),
  .jumpField  (jumpField),
  .isBranchEq (isBranchEq),
  .isJump     (isJump),
  .aluZero    (aluZero),
  .pcOut      (pcOut),
  .pcPlus4    (pcPlus4)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] immField = '0;
  logic [25:0] jumpField = '0;
  logic        isBranchEq = 1'b0;
  logic        isJump = 1'b0;
  logic        aluZero = 1'b0;
  logic [31:0] pcOut;
  logic [31:0] pcPlus4;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [31:0] modelPc = '0;

  always #10 clk = ~clk;  // 50 MHz

  pc_sequencer uut (
    .clk        (clk),
    .rst        (rst),
    .immField   (immField),
    .jumpField  (jumpField),
    .isBranchEq (isBranchEq),
    .isJump     (isJump),
    .aluZero    (aluZero),
    .pcOut      (pcOut),
    .pcPlus4    (pcPlus4)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reset for one edge with conflicting inputs driven (R1)
  task automatic applyReset();
    rst = 1'b1; isJump = 1'b1; isBranchEq = 1'b1; aluZero = 1'b1;
    jumpField = 26'h2AAAAAA; immField = 16'h0011;
    @(posedge clk); @(negedge clk);
    modelPc = 32'h0;
    check("R1", pcOut, 32'h0);
    check("R1", pcPlus4, 32'h4);
    rst = 1'b0; isJump = 1'b0; isBranchEq = 1'b0; aluZero = 1'b0;
  endtask

  // One instruction: drive at negedge, compare after the next rising edge
  task automatic step(bit br, bit jp, bit z, logic [15:0] imm, logic [25:0] jf);
    logic [31:0] inc;
    logic [31:0] nxt;
    int off;
    string tag;
    isBranchEq = br; isJump = jp; aluZero = z; immField = imm; jumpField = jf;
    inc = modelPc + 32'd4;
    off = int'($signed(imm));
    if (jp) nxt = {inc[31:28], jf, 2'b00};
    else if (br && z) nxt = inc + 32'(off * 4);
    else nxt = inc;
    if (jp && br) tag = "R7";
    else if (jp) tag = "R6";
    else if (br && z) tag = "R4";
    else if (br) tag = "R5";
    else if (z) tag = "R8";
    else tag = "R3";
    if (modelPc == 32'hFFFF_FFFC && !jp && !(br && z)) tag = "R10";
    @(posedge clk); @(negedge clk);
    modelPc = nxt;
    check(tag, pcOut, nxt);
    check("R2", pcPlus4, nxt + 32'd4);
    check("R9", {30'h0, pcOut[1:0]}, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    applyReset();
    // R3 sequential
    step(0, 0, 0, 16'h1234, 26'h0);
    step(0, 0, 0, 16'h0, 26'h0);
    step(0, 0, 0, 16'hFFFF, 26'h0);
    // R8 zero flag alone ignored
    step(0, 0, 1, 16'h0040, 26'h1);
    // R5 branch not taken
    step(1, 0, 0, 16'h0005, 26'h0);
    // R4 taken forward and backward
    step(1, 0, 1, 16'h0003, 26'h0);
    step(1, 0, 1, 16'hFFFC, 26'h0);
    // R6 jump to top of region 0
    step(0, 1, 0, 16'h0, 26'h3FFFFFF);
    // R7 jump with taken branch; region comes from incremented PC
    step(1, 1, 1, 16'h0100, 26'h0000010);
    step(1, 1, 0, 16'h0100, 26'h0000020);
    // R1 reset mid-run
    applyReset();
    // R10 wrap: branch back from 0, then advance past the top
    step(1, 0, 1, 16'hFFFE, 26'h0);
    step(0, 0, 0, 16'h0, 26'h0);
    step(1, 0, 1, 16'h7FFF, 26'h0);
    step(1, 0, 1, 16'h8000, 26'h0);
    // R6 jump from high region
    step(1, 0, 1, 16'h8000, 26'h0);
    step(0, 1, 0, 16'h0, 26'h155AA55);
    // Pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1] & r[2], r[3], r[19:4], {r[31:20], r[13:0]});
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule